// File: doc/BRIEF.md
# Descriptor Completion Interrupt Evaluator

This block decides whether the completion of a DMA command descriptor should raise the channel's interrupt. Whenever a descriptor finishes, the command engine gives a one-cycle evaluate strobe. With the strobe it presents the opcode of the finished command and two 2-bit mode fields taken from that descriptor. The block then applies a programmable rule to the channel status word and sets a sticky pending flag for the interrupt controller. The controller clears that flag with an acknowledge pulse. Software can also stop the channel by clearing its run bit. In that case the command engine pulses the same strobe and presents the descriptor that was current at that moment.

Each rule can be one of four kinds: never fire, always fire, fire on a match, or fire on a mismatch. A match means that the status bits selected by a 16-bit mask equal the same bits of a 16-bit pattern. The mask and the pattern share one 32-bit select register. A second select register feeds the same rule to produce a branch-taken result, using the descriptor's branch-mode field. Both select registers are loaded through a single write port.

Top module: `dcie_top`

## Requirements
- R1: After reset, `irq_pending` and `branch_taken` are 0 and both select registers hold 0.
- R2: An evaluate strobe with interrupt mode 0 never sets `irq_pending`.
- R3: An evaluate strobe with interrupt mode 3 and an opcode below 7 sets `irq_pending` at the next clock edge.
- R4: In interrupt mode 1, a strobe sets `irq_pending` only when (status AND sel[31:16]) equals (sel[15:0] AND sel[31:16]). Here sel is the interrupt-select register.
- R5: In interrupt mode 2, a strobe sets `irq_pending` only when the comparison of R4 is false.
- R6: Opcode 7 (the stop command) and every opcode above it never set `irq_pending`, whatever the interrupt mode. Opcodes 0 to 6 are data, quad-access and no-op commands.
- R7: `irq_pending` stays set until an `irq_ack` pulse, and it clears at the edge that samples the acknowledge.
- R8: When a firing strobe and `irq_ack` arrive in the same cycle, `irq_pending` stays set.
- R9: The evaluation uses the status word registered at the clock edge before the strobe cycle. A status change presented in the strobe cycle itself is not seen.
- R10: On each strobe, `branch_taken` loads the result of the R2 to R5 mode rules, applied to the branch mode and the branch-select register. It does this for every opcode. Between strobes it holds its value.
- R11: A write with `cfg_sel` = 0 loads the interrupt-select register, and a write with `cfg_sel` = 1 loads the branch-select register. A strobe in the same cycle as a write uses the previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write enable for a select register |
| cfg_sel | input | 1 | 0 = interrupt select, 1 = branch select |
| cfg_wdata | input | 32 | Select value: mask in 31:16, pattern in 15:0 |
| chan_status | input | 16 | Channel status word |
| eval_stb | input | 1 | One-cycle evaluate strobe |
| cmd_opcode | input | 4 | Opcode of the completed descriptor |
| irq_mode | input | 2 | Interrupt-mode field (descriptor byte 2, bits 5:4) |
| br_mode | input | 2 | Branch-mode field (descriptor byte 2, bits 3:2) |
| irq_ack | input | 1 | Acknowledge that clears the pending flag |
| irq_pending | output | 1 | Sticky interrupt request |
| branch_taken | output | 1 | Branch result of the last evaluation |

## Verification
On every cycle, the assertions check the behaviour of the pending flag. It never rises without a strobe, an acknowledge without a firing strobe clears it, and a firing strobe leaves it set even when an acknowledge arrives with it. The assertions also check that mode 0 and stop-or-higher opcodes never raise the flag, that mode 3 always does, and that `branch_taken` only moves on a strobe. Only the bench's scenarios can show the rest. These are the masked match and mismatch results for chosen status and select values, the one-cycle lag of the status word, and the same-cycle write ordering on the select registers.

// File: rtl/dcie_pkg.sv
// Package: shared encodings for the descriptor completion interrupt evaluator.
// Assumes opcodes are 4 bits wide and that the stop command is opcode 7.
package dcie_pkg;

    // Rule kinds carried in the 2-bit mode fields of a descriptor.
    typedef enum logic [1:0] {
        MODE_NEVER  = 2'd0,
        MODE_MATCH  = 2'd1,
        MODE_MISS   = 2'd2,
        MODE_ALWAYS = 2'd3
    } rule_mode_e;

    // The first opcode that never raises an interrupt.
    localparam logic [3:0] OPC_STOP = 4'd7;

    // Index of each select register in the bank.
    localparam int SEL_IRQ = 0;
    localparam int SEL_BR  = 1;

endpackage

// File: rtl/dcie_sel_bank.sv
// Module: a bank of select registers written through one port.
// Each register holds a mask in its upper half and a pattern in its lower half.
// Assumes the writer presents a valid index whenever we_i is high.
module dcie_sel_bank #(
    parameter int HALF_W = 16,
    parameter int NUM    = 2,
    localparam int REG_W = 2 * HALF_W,
    localparam int IDX_W = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we_i,
    input  logic [IDX_W-1:0]           idx_i,
    input  logic [REG_W-1:0]           wdata_i,
    output logic [NUM-1:0][REG_W-1:0]  sel_o
);

    // One register per slot; each loads when its index is written.
    for (genvar g = 0; g < NUM; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                sel_o[g] <= '0;
            else if (we_i && (idx_i == IDX_W'(g)))
                sel_o[g] <= wdata_i;
        end
    end

endmodule

// File: rtl/dcie_cond.sv
// Module: a combinational rule evaluator.
// It compares the masked status with the masked pattern and then applies
// one of four rule kinds. Assumes sel_i holds the mask in its upper half.
module dcie_cond #(
    parameter int HALF_W = 16,
    localparam int REG_W = 2 * HALF_W
) (
    input  logic [HALF_W-1:0] status_i,
    input  logic [REG_W-1:0]  sel_i,
    input  logic [1:0]        mode_i,
    output logic              hit_o
);
    import dcie_pkg::*;

    logic [HALF_W-1:0] mask;
    logic [HALF_W-1:0] pattern;
    logic              equal;

    // Split the select word and compare only the masked bits.
    always_comb begin
        mask    = sel_i[REG_W-1:HALF_W];
        pattern = sel_i[HALF_W-1:0];
        equal   = ((status_i & mask) == (pattern & mask));
    end

    // Turn the comparison into a decision according to the rule kind.
    always_comb begin
        case (rule_mode_e'(mode_i))
            MODE_NEVER:  hit_o = 1'b0;
            MODE_MATCH:  hit_o = equal;
            MODE_MISS:   hit_o = !equal;
            MODE_ALWAYS: hit_o = 1'b1;
            default:     hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/dcie_sticky.sv
// Module: a sticky request flag.
// It sets on set_i and clears on ack_i; set wins when both are high.
module dcie_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic ack_i,
    output logic q_o
);

    // Hold the request; a set and an acknowledge together leave it set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= 1'b0;
        else if (set_i)
            q_o <= 1'b1;
        else if (ack_i)
            q_o <= 1'b0;
    end

    // The flag only rises on a set.
    assert_rise_needs_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_o) |-> $past(set_i));

    // An acknowledge with no set clears the flag.
    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !set_i) |=> !q_o);

    // A set is never lost, even with an acknowledge beside it.
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);

endmodule

// File: rtl/dcie_top.sv
// Module: the descriptor completion interrupt evaluator.
// On each evaluate strobe it applies the descriptor's interrupt rule, which
// sets a sticky pending flag, and its branch rule, which loads branch_taken.
// Both rules use the status word registered one cycle earlier.
// Assumes eval_stb is high for a single cycle for each completed descriptor.
module dcie_top #(
    parameter int          STATUS_W = 16,
    parameter int          OPC_W    = 4,
    parameter logic [3:0]  STOP_OPC = dcie_pkg::OPC_STOP,
    localparam int         SEL_W    = 2 * STATUS_W,
    localparam int         NUM_SEL  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic                 cfg_sel,
    input  logic [SEL_W-1:0]     cfg_wdata,
    input  logic [STATUS_W-1:0]  chan_status,
    input  logic                 eval_stb,
    input  logic [OPC_W-1:0]     cmd_opcode,
    input  logic [1:0]           irq_mode,
    input  logic [1:0]           br_mode,
    input  logic                 irq_ack,
    output logic                 irq_pending,
    output logic                 branch_taken
);
    import dcie_pkg::*;

    logic [NUM_SEL-1:0][SEL_W-1:0] sel_regs;
    logic [STATUS_W-1:0]           status_q;
    logic [NUM_SEL-1:0][1:0]       modes;
    logic [NUM_SEL-1:0]            hits;
    logic                          irq_allowed;
    logic                          irq_fire;

    // The select registers, loaded through the shared write port.
    dcie_sel_bank #(.HALF_W(STATUS_W), .NUM(NUM_SEL)) u_sel_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .idx_i   (cfg_sel),
        .wdata_i (cfg_wdata),
        .sel_o   (sel_regs)
    );

    // Register the status word so that evaluation sees the previous cycle's value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= '0;
        else
            status_q <= chan_status;
    end

    // Route each descriptor mode field to its rule evaluator.
    always_comb begin
        modes[SEL_IRQ] = irq_mode;
        modes[SEL_BR]  = br_mode;
    end

    // One rule evaluator per select register.
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_cond
        dcie_cond #(.HALF_W(STATUS_W)) u_cond (
            .status_i (status_q),
            .sel_i    (sel_regs[g]),
            .mode_i   (modes[g]),
            .hit_o    (hits[g])
        );
    end

    // Stop and higher opcodes are barred from interrupting.
    always_comb begin
        irq_allowed = (cmd_opcode < OPC_W'(STOP_OPC));
        irq_fire    = eval_stb && irq_allowed && hits[SEL_IRQ];
    end

    // The sticky pending flag seen by the interrupt controller.
    dcie_sticky u_pending (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (irq_fire),
        .ack_i (irq_ack),
        .q_o   (irq_pending)
    );

    // Capture the branch decision on each strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            branch_taken <= 1'b0;
        else if (eval_stb)
            branch_taken <= hits[SEL_BR];
    end

    // Mode 0 never raises the flag.
    assert_mode_never_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_stb && irq_mode == 2'd0 && !irq_pending) |=> !irq_pending);

    // Mode 3 with a permitted opcode always raises the flag.
    assert_mode_always_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_stb && irq_mode == 2'd3 && cmd_opcode < OPC_W'(STOP_OPC)) |=> irq_pending);

    // Stop and higher opcodes never raise the flag.
    assert_stop_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_stb && cmd_opcode >= OPC_W'(STOP_OPC) && !irq_pending) |=> !irq_pending);

    // The branch result only changes on a strobe.
    assert_branch_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_stb |=> $stable(branch_taken));

endmodule

// File: tb/dcie_top_tb_top.sv
module dcie_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic        cfg_sel;
    logic [31:0] cfg_wdata;
    logic [15:0] chan_status;
    logic        eval_stb;
    logic [3:0]  cmd_opcode;
    logic [1:0]  irq_mode;
    logic [1:0]  br_mode;
    logic        irq_ack;
    logic        irq_pending;
    logic        branch_taken;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dcie_top dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_sel      (cfg_sel),
        .cfg_wdata    (cfg_wdata),
        .chan_status  (chan_status),
        .eval_stb     (eval_stb),
        .cmd_opcode   (cmd_opcode),
        .irq_mode     (irq_mode),
        .br_mode      (br_mode),
        .irq_ack      (irq_ack),
        .irq_pending  (irq_pending),
        .branch_taken (branch_taken)
    );

    // Reference rule, written from the requirements.
    function automatic bit rule(input logic [15:0] st, input logic [31:0] sel,
                                input logic [1:0] mode);
        bit eq;
        eq = ((st & sel[31:16]) == (sel[15:0] & sel[31:16]));
        case (mode)
            2'd0: return 1'b0;
            2'd1: return eq;
            2'd2: return !eq;
            default: return 1'b1;
        endcase
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // Advance one edge and settle just after it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_cfg(input logic which, input logic [31:0] data);
        cfg_we = 1'b1; cfg_sel = which; cfg_wdata = data;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic set_status(input logic [15:0] st);
        chan_status = st;
        tick();
    endtask

    task automatic strobe(input logic [3:0] opc, input logic [1:0] im,
                          input logic [1:0] bm, input logic ack);
        eval_stb = 1'b1; cmd_opcode = opc; irq_mode = im; br_mode = bm; irq_ack = ack;
        tick();
        eval_stb = 1'b0; irq_ack = 1'b0;
    endtask

    task automatic ack_pulse();
        irq_ack = 1'b1;
        tick();
        irq_ack = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        check("R1 pending after reset", irq_pending, 1'b0);
        check("R1 branch after reset", branch_taken, 1'b0);
        // The interrupt select is zero, so mode 1 must match.
        strobe(4'd0, 2'd1, 2'd2, 1'b0);
        check("R1 zero irq select matches", irq_pending, 1'b1);
        check("R1 zero branch select never misses", branch_taken, 1'b0);
        ack_pulse();
    endtask

    task automatic t_mode0();
        wr_cfg(1'b0, 32'h0000_0000);
        set_status(16'h1234);
        strobe(4'd2, 2'd0, 2'd0, 1'b0);
        check("R2 mode 0 never", irq_pending, 1'b0);
    endtask

    task automatic t_mode3_sticky();
        strobe(4'd1, 2'd3, 2'd0, 1'b0);
        check("R3 mode 3 always", irq_pending, 1'b1);
        tick(); tick(); tick();
        check("R7 pending holds without ack", irq_pending, 1'b1);
        ack_pulse();
        check("R7 ack clears", irq_pending, 1'b0);
    endtask

    task automatic t_match_miss();
        logic [31:0] sel;
        sel = 32'h00F0_0050;
        wr_cfg(1'b0, sel);
        set_status(16'h1250);
        strobe(4'd0, 2'd1, 2'd0, 1'b0);
        check("R4 mode 1 match", irq_pending, rule(16'h1250, sel, 2'd1));
        ack_pulse();
        strobe(4'd3, 2'd2, 2'd0, 1'b0);
        check("R5 mode 2 with match", irq_pending, rule(16'h1250, sel, 2'd2));
        set_status(16'h1260);
        strobe(4'd0, 2'd1, 2'd0, 1'b0);
        check("R4 mode 1 mismatch", irq_pending, rule(16'h1260, sel, 2'd1));
        strobe(4'd2, 2'd2, 2'd0, 1'b0);
        check("R5 mode 2 mismatch", irq_pending, rule(16'h1260, sel, 2'd2));
        ack_pulse();
        // Bits outside the mask are ignored.
        set_status(16'hFF5F);
        strobe(4'd0, 2'd1, 2'd0, 1'b0);
        check("R4 unmasked bits ignored", irq_pending, rule(16'hFF5F, sel, 2'd1));
        ack_pulse();
    endtask

    task automatic t_stop();
        strobe(4'd7, 2'd3, 2'd0, 1'b0);
        check("R6 opcode 7 quiet", irq_pending, 1'b0);
        strobe(4'd15, 2'd3, 2'd0, 1'b0);
        check("R6 opcode 15 quiet", irq_pending, 1'b0);
        strobe(4'd6, 2'd3, 2'd0, 1'b0);
        check("R6 opcode 6 fires", irq_pending, 1'b1);
        ack_pulse();
    endtask

    task automatic t_collide();
        strobe(4'd0, 2'd3, 2'd0, 1'b0);
        strobe(4'd0, 2'd3, 2'd0, 1'b1);
        check("R8 set wins over ack", irq_pending, 1'b1);
        strobe(4'd0, 2'd0, 2'd0, 1'b1);
        check("R8 ack with quiet strobe clears", irq_pending, 1'b0);
    endtask

    task automatic t_status_lag();
        wr_cfg(1'b0, 32'hFFFF_00AA);
        set_status(16'h00AA);
        chan_status = 16'h0055;
        strobe(4'd0, 2'd1, 2'd0, 1'b0);
        check("R9 old status used", irq_pending, 1'b1);
        ack_pulse();
        strobe(4'd0, 2'd1, 2'd0, 1'b0);
        check("R9 new status seen next cycle", irq_pending, 1'b0);
    endtask

    task automatic t_branch();
        wr_cfg(1'b1, 32'h0003_0001);
        set_status(16'h0001);
        strobe(4'd7, 2'd0, 2'd1, 1'b0);
        check("R10 branch match with stop opcode", branch_taken, 1'b1);
        check("R11 irq select untouched by branch write", irq_pending, 1'b0);
        set_status(16'h0002);
        tick();
        check("R10 branch holds between strobes", branch_taken, 1'b1);
        strobe(4'd0, 2'd0, 2'd0, 1'b0);
        check("R10 branch mode 0", branch_taken, 1'b0);
        strobe(4'd0, 2'd0, 2'd2, 1'b0);
        check("R10 branch mode 2 mismatch", branch_taken, 1'b1);
    endtask

    task automatic t_cfg_order();
        // The interrupt select currently requires status 00AA; the status is 0002.
        cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 32'h0000_0000;
        strobe(4'd0, 2'd1, 2'd0, 1'b0);
        cfg_we = 1'b0;
        check("R11 same-cycle write not used", irq_pending, 1'b0);
        strobe(4'd0, 2'd1, 2'd0, 1'b0);
        check("R11 write used afterwards", irq_pending, 1'b1);
        ack_pulse();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
        chan_status = '0; eval_stb = 1'b0; cmd_opcode = '0;
        irq_mode = '0; br_mode = '0; irq_ack = 1'b0;
        #1;
        t_reset();
        t_mode0();
        t_mode3_sticky();
        t_match_miss();
        t_stop();
        t_collide();
        t_status_lag();
        t_branch();
        t_cfg_order();
        finish_run();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

endmodule